// File: doc/BRIEF.md
# Program Memory Self-Programming Controller

This block lets a small processor core read, write and erase its own program storage while it runs. The core sees a 16-bit data buffer and a 24-bit byte pointer as byte registers in its data space, and it issues one of seven word commands on a valid/ready command port. Program RAM accesses are blocking: the command port withdraws `cmd_ready` until the access ends, so the core stalls. Flash read, flash write, flash erase and external-memory accesses run in the background. They hold `busy` high for a latency set by a parameter.

A command counts as accepted on any clock edge where `cmd_valid` and `cmd_ready` are both high. This acceptance is the moment the core's program counter moves on. `cmd_ready` drops only while a blocking RAM access is in progress. While `cmd_valid` is high and `cmd_ready` is low, the core must hold `cmd_op` steady. Some commands are accepted but do nothing else: a reserved code, a flash command while `permit` is low, a flash command aimed at external space, and any background command issued while `busy` is set. Such a command changes no register, no memory and no flag. Flash, RAM and external memory are modelled here as small word arrays. Code protection does not exist in this block, so every word stays reachable.

Register select codes: 0 = buffer low byte, 1 = buffer high byte, 2 = pointer bits 7:0, 3 = pointer bits 15:8, 4 = pointer bits 23:16, 5 = add the written byte to the pointer (write only), 6 = subtract the written byte from the pointer (write only), 7 = status (read only; bit 0 = busy). Command codes: 0 read, 1 read with pointer increment, 2 write, 3 write with pointer increment (these four target RAM when pointer bit 23 is 0 and external memory when it is 1), 4 flash read, 5 flash write, 6 flash erase, 7 reserved.

Top module: `progmem_selfprog`

## Requirements
- R1: After reset the buffer and the pointer read 0, `busy` is 0 and `cmd_ready` is 1. RAM and external words hold 0, and flash words hold 16'hFFFF.
- R2: A register write with select 0..4 loads that byte, and `reg_rdata` returns it combinationally. Select 7 reads {7'b0, busy}.
- R3: Pointer bit 0 is ignored. The word index comes from the pointer bits above bit 0.
- R4: Select 5 adds the byte to the 24-bit pointer, and select 6 subtracts it. The carry or borrow runs into bits 23:8, and the pointer wraps modulo 2^24.
- R5: An accepted RAM command (codes 0..3, bit 23 clear) pulls `cmd_ready` low for the next 3 cycles. It finishes at the 4th edge after acceptance, counting the accepting edge as the first.
- R6: An accepted flash or external command keeps `cmd_ready` high. It holds `busy` high for exactly its latency in cycles, and its effect lands on the edge where `busy` clears.
- R7: With `permit` low, codes 4..6 are no-ops.
- R8: While `busy` is high, flash and external commands are no-ops, and RAM commands still run.
- R9: Codes 1 and 3, when they run, add 2 to the full 24-bit pointer with carry. A no-op leaves the pointer unchanged.
- R10: After a flash read, the buffer keeps its old value until `busy` clears. The read latency is at least 4 cycles.
- R11: A flash write ANDs the data into the word, so it only clears bits. A flash erase sets every word of the aligned erase page to 16'hFFFF and leaves other pages alone.
- R12: Code 7, and codes 4..6 with pointer bit 23 set, are no-ops.
- R13: Codes 0..3 with pointer bit 23 set access external memory in the background. RAM is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Data-space register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte (combinational) |
| cmd_valid | input | 1 | Command valid |
| cmd_op | input | 3 | Command code |
| cmd_ready | output | 1 | Command ready; low while a RAM access stalls the core |
| permit | input | 1 | Flash write-permit configuration bit |
| busy | output | 1 | Background operation in progress |

## Verification
The pointer arithmetic is swept over all 256 low-byte values. The upper bytes are chosen so that the sweep hits carry into a saturated middle byte, borrow, and wrap at 2^24; this separates a byte-only adder from a full carry chain. Every RAM word is written and then read back through the auto-incrementing commands, starting from an odd pointer. This shows whether bit 0 is ignored and whether each word is addressed on its own. Flash is driven with erase, overlapping writes, and writes into other pages, which shows AND-write behaviour and page bounds. The no-op causes are each tried alone: missing permit, busy, external target and the reserved code. In each case a later read shows that nothing changed. Cycle-exact sampling of `cmd_ready`, `busy` and the buffer separates the stalling path from the background path.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int BLK_CYCLES = 4;

  typedef enum logic [2:0] {
    OP_IRD  = 3'd0,
    OP_IRDI = 3'd1,
    OP_IWR  = 3'd2,
    OP_IWRI = 3'd3,
    OP_FRD  = 3'd4,
    OP_FWR  = 3'd5,
    OP_FER  = 3'd6,
    OP_RSV  = 3'd7
  } sp_op_e;

  typedef enum logic [2:0] {
    RA_DLO  = 3'd0,
    RA_DHI  = 3'd1,
    RA_P0   = 3'd2,
    RA_P1   = 3'd3,
    RA_P2   = 3'd4,
    RA_ADD  = 3'd5,
    RA_SUB  = 3'd6,
    RA_STAT = 3'd7
  } sp_reg_e;

  typedef enum logic [2:0] {
    NB_NONE = 3'd0,
    NB_FRD  = 3'd1,
    NB_FWR  = 3'd2,
    NB_FER  = 3'd3,
    NB_XRD  = 3'd4,
    NB_XWR  = 3'd5
  } nb_kind_e;

  typedef struct packed {
    logic     ram_go;
    logic     nb_go;
    nb_kind_e kind;
    logic     is_wr;
    logic     inc;
  } sp_dec_t;
endpackage

// File: rtl/sp_word_mem.sv
module sp_word_mem #(
  parameter int          WORDS  = 16,
  parameter logic [15:0] RST_VAL = 16'h0000,
  parameter bit          AND_WR = 1'b0,
  parameter int          PAGE   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [15:0]              rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [15:0]              wr_data,
  input  logic                     er_en,
  input  logic [$clog2(WORDS)-1:0] er_idx
);
  localparam int IW = $clog2(WORDS);
  localparam int PW = $clog2(PAGE);

  logic [15:0] mem [WORDS];
  logic [15:0] wr_val;
  logic        unused_er;

  assign rd_data   = mem[rd_idx];
  assign unused_er = ^er_idx[PW-1:0];

  generate
    if (AND_WR) begin : g_and
      assign wr_val = mem[wr_idx] & wr_data;
    end else begin : g_plain
      assign wr_val = wr_data;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= RST_VAL;
    end else begin
      if (wr_en) mem[wr_idx] <= wr_val;
      if (er_en) begin
        for (int p = 0; p < PAGE; p++)
          mem[{er_idx[IW-1:PW], PW'(p)}] <= RST_VAL;
      end
    end
  end
endmodule

// File: rtl/sp_decode.sv
module sp_decode import sp_pkg::*; (
  input  logic [2:0] op,
  input  logic       ptr_ext,
  input  logic       permit,
  input  logic       busy,
  output sp_dec_t    dec
);
  logic is_i, is_f, x_go, f_go;
  sp_op_e o;

  always_comb begin
    o    = sp_op_e'(op);
    is_i = (o == OP_IRD) || (o == OP_IRDI) || (o == OP_IWR) || (o == OP_IWRI);
    is_f = (o == OP_FRD) || (o == OP_FWR) || (o == OP_FER);
    x_go = is_i && ptr_ext && !busy;
    f_go = is_f && !ptr_ext && permit && !busy;

    dec        = '0;
    dec.ram_go = is_i && !ptr_ext;
    dec.nb_go  = x_go || f_go;
    dec.is_wr  = (o == OP_IWR) || (o == OP_IWRI);
    dec.inc    = ((o == OP_IRDI) || (o == OP_IWRI)) && (dec.ram_go || x_go);
    if (x_go)
      dec.kind = dec.is_wr ? NB_XWR : NB_XRD;
    else if (f_go) begin
      case (o)
        OP_FRD:  dec.kind = NB_FRD;
        OP_FWR:  dec.kind = NB_FWR;
        default: dec.kind = NB_FER;
      endcase
    end else
      dec.kind = NB_NONE;
  end
endmodule

// File: rtl/sp_sequencer.sv
module sp_sequencer import sp_pkg::*; #(
  parameter int FRD_LAT  = 6,
  parameter int FWR_LAT  = 40,
  parameter int FER_LAT  = 200,
  parameter int XMEM_LAT = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  sp_dec_t     dec,
  input  logic [23:0] ptr,
  input  logic [15:0] dbuf,
  output logic        blk_busy,
  output logic        ram_done,
  output logic        blk_wr,
  output logic [23:0] blk_addr,
  output logic [15:0] blk_data,
  output logic        nb_busy,
  output logic        nb_done,
  output nb_kind_e    nb_kind,
  output logic [23:0] nb_addr,
  output logic [15:0] nb_data
);
  localparam int M1     = (FRD_LAT > FWR_LAT) ? FRD_LAT : FWR_LAT;
  localparam int M2     = (FER_LAT > XMEM_LAT) ? FER_LAT : XMEM_LAT;
  localparam int MAXLAT = (M1 > M2) ? M1 : M2;
  localparam int CW     = $clog2(MAXLAT + 1);
  localparam int BW     = $clog2(BLK_CYCLES);

  logic [BW-1:0] blk_cnt;
  logic [CW-1:0] nb_cnt, nb_lat;
  logic          unused_inc;

  assign unused_inc = dec.inc;

  always_comb begin
    case (dec.kind)
      NB_FRD:  nb_lat = CW'(FRD_LAT);
      NB_FWR:  nb_lat = CW'(FWR_LAT);
      NB_FER:  nb_lat = CW'(FER_LAT);
      default: nb_lat = CW'(XMEM_LAT);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_cnt  <= '0;
      blk_wr   <= 1'b0;
      blk_addr <= '0;
      blk_data <= '0;
    end else if (accept && dec.ram_go) begin
      blk_cnt  <= BW'(BLK_CYCLES - 1);
      blk_wr   <= dec.is_wr;
      blk_addr <= ptr;
      blk_data <= dbuf;
    end else if (blk_cnt != '0) begin
      blk_cnt <= blk_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nb_cnt  <= '0;
      nb_kind <= NB_NONE;
      nb_addr <= '0;
      nb_data <= '0;
    end else if (accept && dec.nb_go) begin
      nb_cnt  <= nb_lat;
      nb_kind <= dec.kind;
      nb_addr <= ptr;
      nb_data <= dbuf;
    end else if (nb_cnt != '0) begin
      nb_cnt <= nb_cnt - 1'b1;
    end
  end

  assign blk_busy = (blk_cnt != '0);
  assign ram_done = (blk_cnt == BW'(1));
  assign nb_busy  = (nb_cnt != '0);
  assign nb_done  = (nb_cnt == CW'(1));
endmodule

// File: rtl/sp_regs.sv
module sp_regs import sp_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        inc2,
  input  logic        buf_ld,
  input  logic [15:0] buf_val,
  input  logic        busy,
  output logic [23:0] ptr,
  output logic [15:0] dbuf
);
  logic [23:0] ptr_nx;
  logic [15:0] buf_nx;

  always_comb begin
    ptr_nx = inc2   ? ptr + 24'd2 : ptr;
    buf_nx = buf_ld ? buf_val     : dbuf;
    if (reg_wr) begin
      case (sp_reg_e'(reg_addr))
        RA_DLO:  buf_nx = {dbuf[15:8], reg_wdata};
        RA_DHI:  buf_nx = {reg_wdata, dbuf[7:0]};
        RA_P0:   ptr_nx = {ptr[23:8], reg_wdata};
        RA_P1:   ptr_nx = {ptr[23:16], reg_wdata, ptr[7:0]};
        RA_P2:   ptr_nx = {reg_wdata, ptr[15:0]};
        RA_ADD:  ptr_nx = ptr + {16'h0000, reg_wdata};
        RA_SUB:  ptr_nx = ptr - {16'h0000, reg_wdata};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      dbuf <= '0;
    end else begin
      ptr  <= ptr_nx;
      dbuf <= buf_nx;
    end
  end

  always_comb begin
    case (sp_reg_e'(reg_addr))
      RA_DLO:  reg_rdata = dbuf[7:0];
      RA_DHI:  reg_rdata = dbuf[15:8];
      RA_P0:   reg_rdata = ptr[7:0];
      RA_P1:   reg_rdata = ptr[15:8];
      RA_P2:   reg_rdata = ptr[23:16];
      RA_STAT: reg_rdata = {7'b0, busy};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/progmem_selfprog.sv
module progmem_selfprog import sp_pkg::*; #(
  parameter int RAM_WORDS   = 16,
  parameter int FLASH_WORDS = 32,
  parameter int XMEM_WORDS  = 16,
  parameter int ERASE_PAGE  = 4,
  parameter int FRD_LAT     = 6,
  parameter int FWR_LAT     = 40,
  parameter int FER_LAT     = 200,
  parameter int XMEM_LAT    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  output logic       cmd_ready,
  input  logic       permit,
  output logic       busy
);
  localparam int RAM_IW = $clog2(RAM_WORDS);
  localparam int FL_IW  = $clog2(FLASH_WORDS);
  localparam int XM_IW  = $clog2(XMEM_WORDS);

  sp_dec_t     dec;
  logic        accept, blk_busy, ram_done, blk_wr, nb_done;
  logic [23:0] ptr, blk_addr, nb_addr;
  logic [15:0] dbuf, blk_data, nb_data;
  nb_kind_e    nb_kind;
  logic [15:0] ram_rd, fl_rd, xm_rd, buf_val;
  logic        buf_ld;
  logic        unused_addr;

  assign cmd_ready   = !blk_busy;
  assign accept      = cmd_valid && cmd_ready;
  assign unused_addr = ^{blk_addr, nb_addr};

  sp_decode u_dec (
    .op(cmd_op), .ptr_ext(ptr[23]), .permit(permit), .busy(busy), .dec(dec)
  );

  sp_sequencer #(
    .FRD_LAT(FRD_LAT), .FWR_LAT(FWR_LAT), .FER_LAT(FER_LAT), .XMEM_LAT(XMEM_LAT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .dec(dec), .ptr(ptr), .dbuf(dbuf),
    .blk_busy(blk_busy), .ram_done(ram_done), .blk_wr(blk_wr),
    .blk_addr(blk_addr), .blk_data(blk_data),
    .nb_busy(busy), .nb_done(nb_done), .nb_kind(nb_kind),
    .nb_addr(nb_addr), .nb_data(nb_data)
  );

  always_comb begin
    buf_ld  = 1'b0;
    buf_val = ram_rd;
    if (ram_done && !blk_wr) begin
      buf_ld  = 1'b1;
      buf_val = ram_rd;
    end else if (nb_done && nb_kind == NB_FRD) begin
      buf_ld  = 1'b1;
      buf_val = fl_rd;
    end else if (nb_done && nb_kind == NB_XRD) begin
      buf_ld  = 1'b1;
      buf_val = xm_rd;
    end
  end

  sp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .inc2(accept && dec.inc), .buf_ld(buf_ld), .buf_val(buf_val),
    .busy(busy), .ptr(ptr), .dbuf(dbuf)
  );

  sp_word_mem #(.WORDS(RAM_WORDS), .RST_VAL(16'h0000), .AND_WR(1'b0), .PAGE(ERASE_PAGE)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(blk_addr[RAM_IW:1]), .rd_data(ram_rd),
    .wr_en(ram_done && blk_wr), .wr_idx(blk_addr[RAM_IW:1]), .wr_data(blk_data),
    .er_en(1'b0), .er_idx(blk_addr[RAM_IW:1])
  );

  sp_word_mem #(.WORDS(FLASH_WORDS), .RST_VAL(16'hFFFF), .AND_WR(1'b1), .PAGE(ERASE_PAGE)) u_flash (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(nb_addr[FL_IW:1]), .rd_data(fl_rd),
    .wr_en(nb_done && nb_kind == NB_FWR), .wr_idx(nb_addr[FL_IW:1]), .wr_data(nb_data),
    .er_en(nb_done && nb_kind == NB_FER), .er_idx(nb_addr[FL_IW:1])
  );

  sp_word_mem #(.WORDS(XMEM_WORDS), .RST_VAL(16'h0000), .AND_WR(1'b0), .PAGE(ERASE_PAGE)) u_xmem (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(nb_addr[XM_IW:1]), .rd_data(xm_rd),
    .wr_en(nb_done && nb_kind == NB_XWR), .wr_idx(nb_addr[XM_IW:1]), .wr_data(nb_data),
    .er_en(1'b0), .er_idx(nb_addr[XM_IW:1])
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker import sp_pkg::*; (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [2:0]  cmd_op,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        permit,
  input logic        busy,
  input logic [23:0] ptr
);
  logic acc, ram_acc, fl_acc;
  assign acc     = cmd_valid && cmd_ready;
  assign ram_acc = acc && (cmd_op <= 3'd3) && !ptr[23];
  assign fl_acc  = acc && (cmd_op >= 3'd4) && (cmd_op <= 3'd6);

  assert_ram_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_acc |=> !cmd_ready ##1 !cmd_ready ##1 !cmd_ready ##1 cmd_ready);

  assert_bg_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_acc && permit && !busy && !ptr[23]) |=> (busy && cmd_ready));

  assert_no_permit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_acc && !permit && !busy) |=> !busy);

  assert_busy_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_acc && busy && !reg_wr) |=> $stable(ptr));

  assert_autoinc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_acc && (cmd_op == 3'd1 || cmd_op == 3'd3) && !reg_wr) |=> (ptr == $past(ptr) + 24'd2));

  assert_ptr_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd5) |=> (ptr == $past(ptr) + {16'h0000, $past(reg_wdata)}));

  assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd7 && !reg_wr) |=> ($stable(ptr) && cmd_ready));
endmodule

bind progmem_selfprog sp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .permit(permit), .busy(busy), .ptr(ptr)
);

// File: tb/progmem_selfprog_bench.sv
module progmem_selfprog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRD_L = 6;
  localparam int XM_L  = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic       cmd_ready;
  logic       permit;
  logic       busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  progmem_selfprog u_progmem_selfprog (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_ready(cmd_ready), .permit(permit), .busy(busy)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 4951 + 3855);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ptr(input logic [23:0] p);
    wr_reg(3'd2, p[7:0]); wr_reg(3'd3, p[15:8]); wr_reg(3'd4, p[23:16]);
  endtask

  task automatic set_buf(input logic [15:0] v);
    wr_reg(3'd0, v[7:0]); wr_reg(3'd1, v[15:8]);
  endtask

  task automatic get_ptr(output logic [23:0] p);
    logic [7:0] b0, b1, b2;
    rd_reg(3'd2, b0); rd_reg(3'd3, b1); rd_reg(3'd4, b2);
    p = {b2, b1, b0};
  endtask

  task automatic get_buf(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(3'd0, lo); rd_reg(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic issue(input logic [2:0] op);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || !cmd_ready) @(negedge clk);
  endtask

  task automatic run_read(input logic [2:0] op, input logic [23:0] p, output logic [15:0] v);
    set_ptr(p); issue(op); wait_idle(); get_buf(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R5 actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] p, base, e;
    logic [15:0] v, ob;
    logic [7:0]  b, k;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cmd_valid = 1'b0; cmd_op = '0; permit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    get_ptr(p); chk("R1 ptr", p, 0);
    get_buf(v); chk("R1 buf", v, 0);
    rd_reg(3'd7, b); chk("R1 R2 status", b, 0);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 busy", busy, 0);

    // R2 byte registers
    set_ptr(24'hA1B2C3); get_ptr(p); chk("R2 ptr bytes", p, 24'hA1B2C3);
    set_buf(16'h5AC3); get_buf(v); chk("R2 buf bytes", v, 16'h5AC3);
    rd_reg(3'd5, b); chk("R2 add reads zero", b, 0);

    // R4 carry/borrow sweep over the low byte
    for (int lo = 0; lo < 256; lo++) begin
      k = 8'(lo * 7 + 3);
      base = {((lo & 2) != 0) ? 8'hFF : 8'h00, ((lo & 1) != 0) ? 8'hFF : 8'h34, 8'(lo)};
      set_ptr(base);
      wr_reg(3'd5, k); get_ptr(p); e = base + {16'h0, k}; chk("R4 add", p, e);
      wr_reg(3'd6, k); get_ptr(p); chk("R4 sub back", p, base);
      wr_reg(3'd6, k); get_ptr(p); e = base - {16'h0, k}; chk("R4 sub borrow", p, e);
    end

    // R5 blocking write and read timing
    set_buf(16'h1234); set_ptr(24'h000006);
    issue(3'd2);
    chk("R5 stall c1", cmd_ready, 0); @(negedge clk);
    chk("R5 stall c2", cmd_ready, 0); @(negedge clk);
    chk("R5 stall c3", cmd_ready, 0); @(negedge clk);
    chk("R5 ready c4", cmd_ready, 1);
    set_buf(16'h0000); set_ptr(24'h000006);
    issue(3'd0);
    @(negedge clk); @(negedge clk);
    get_buf(v); chk("R5 buf old at c3", v, 0);
    @(negedge clk);
    get_buf(v); chk("R5 buf new at c4", v, 16'h1234);
    chk("R5 no busy", busy, 0);

    // R9 R3 sweep every RAM word with auto-increment
    set_ptr(24'h000000);
    for (int i = 0; i < 16; i++) begin
      set_buf(pat(i)); issue(3'd3); wait_idle();
    end
    get_ptr(p); chk("R9 ptr after writes", p, 24'd32);
    set_ptr(24'h000001);
    for (int i = 0; i < 16; i++) begin
      issue(3'd1); wait_idle(); get_buf(v); chk("R3 R9 RAM word", v, pat(i));
    end
    get_ptr(p); chk("R9 ptr after reads", p, 24'd33);
    set_ptr(24'h00FFFE); issue(3'd1); wait_idle();
    get_ptr(p); chk("R9 carry", p, 24'h010000);
    get_buf(v); chk("R9 word at carry", v, pat(15));

    // R13 R6 external memory
    set_buf(16'hBEEF); set_ptr(24'h800010);
    issue(3'd2);
    for (int c = 1; c <= XM_L; c++) begin
      chk("R6 ext busy", busy, 1);
      chk("R6 ext ready", cmd_ready, 1);
      @(negedge clk);
    end
    chk("R6 ext busy clear", busy, 0);
    set_buf(16'h0000);
    run_read(3'd0, 24'h800010, v); chk("R13 ext read", v, 16'hBEEF);
    run_read(3'd0, 24'h000010, v); chk("R13 RAM untouched", v, pat(8));

    // R1 R10 R6 flash read timing
    permit = 1'b1;
    set_buf(16'h0000); set_ptr(24'h000008);
    issue(3'd4);
    for (int c = 1; c <= FRD_L; c++) begin
      chk("R6 flash busy", busy, 1);
      if (c == 4) begin get_buf(v); chk("R10 buf held", v, 0); end
      @(negedge clk);
    end
    chk("R6 flash busy clear", busy, 0);
    get_buf(v); chk("R1 R10 flash erased value", v, 16'hFFFF);

    // R11 AND write and page erase
    set_buf(16'hA5C3); set_ptr(24'h000008); issue(3'd5); wait_idle();
    set_buf(16'h0F0F); set_ptr(24'h000008); issue(3'd5); wait_idle();
    run_read(3'd4, 24'h000008, v); chk("R11 AND write", v, 16'h0503);
    set_buf(16'h1234); set_ptr(24'h00000A); issue(3'd5); wait_idle();
    set_buf(16'h00FF); set_ptr(24'h000004); issue(3'd5); wait_idle();
    set_ptr(24'h00000A); issue(3'd6); wait_idle();
    run_read(3'd4, 24'h000008, v); chk("R11 erase word4", v, 16'hFFFF);
    run_read(3'd4, 24'h00000A, v); chk("R11 erase word5", v, 16'hFFFF);
    run_read(3'd4, 24'h000004, v); chk("R11 other page kept", v, 16'h00FF);

    // R7 permit clear
    permit = 1'b0;
    set_buf(16'h1111); set_ptr(24'h000008); issue(3'd5);
    chk("R7 no busy on write", busy, 0);
    set_ptr(24'h000004); issue(3'd6);
    chk("R7 no busy on erase", busy, 0);
    permit = 1'b1;
    run_read(3'd4, 24'h000008, v); chk("R7 word4 unchanged", v, 16'hFFFF);
    run_read(3'd4, 24'h000004, v); chk("R7 word2 unchanged", v, 16'h00FF);

    // R8 busy rejection, RAM still served
    set_buf(16'h7777); set_ptr(24'h00000C); issue(3'd5);
    set_ptr(24'h800020); issue(3'd1);
    chk("R8 still busy", busy, 1);
    get_ptr(p); chk("R8 rejected ptr kept", p, 24'h800020);
    set_ptr(24'h000004); issue(3'd6);
    set_ptr(24'h000010); issue(3'd0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R8 busy during RAM", busy, 1);
    get_buf(v); chk("R8 RAM read while busy", v, pat(8));
    wait_idle();
    run_read(3'd4, 24'h000004, v); chk("R8 erase rejected", v, 16'h00FF);
    run_read(3'd4, 24'h00000C, v); chk("R8 first write done", v, 16'h7777);

    // R12 reserved code and flash aimed at external space
    set_buf(16'h4321); set_ptr(24'h80000A);
    issue(3'd7);
    chk("R12 reserved ready", cmd_ready, 1);
    chk("R12 reserved busy", busy, 0);
    get_ptr(p); chk("R12 reserved ptr", p, 24'h80000A);
    get_buf(ob); chk("R12 reserved buf", ob, 16'h4321);
    issue(3'd4); chk("R12 fread ext busy", busy, 0);
    issue(3'd6); chk("R12 ferase ext busy", busy, 0);
    @(negedge clk);
    get_buf(v); chk("R12 buf unchanged", v, 16'h4321);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule